// File: doc/BRIEF.md
# Page Write Buffer and Program Timer

This block sits behind the serial command decoder of a small serial non-volatile memory. When a write command opens, it takes a start strobe with the 13-bit target address and the current state of the write-enable latch. It then collects each received data byte into a 32-entry page buffer. Every entry carries its own valid flag. Bytes land at successive offsets within one page. When more than a page of bytes arrives, the offset wraps and later bytes replace earlier ones.

The buffer is committed only when chip select rises on a clean byte boundary and at least one whole byte has been received. In that case the block raises a busy flag for a programmable number of system-clock cycles. During the first 32 of those cycles it scans the buffer and writes one entry per clock to the array write port. A separate protection block answers, for each presented address, whether a write is allowed; entries that are refused are skipped. In the last busy cycle the block pulses a request that clears the write-enable latch. A command opened while write-enable is clear is dropped until chip select rises, and so is any command that ends off a byte boundary.

Top module: `pwb_page_writer`

## Requirements
- R1: While rst_ni is low and right after it is released, busy_o, mem_we_o and wen_clr_o are all 0.
- R2: A start_i pulse with wen_i=1 fixes the page to base_addr_i[12:5] and the first offset to base_addr_i[4:0]. Each byte_valid_i pulse stores byte_data_i at the current offset and then adds one to the offset.
- R3: The offset is 5 bits and wraps from 31 to 0 inside the same page. A byte sent to an offset that already holds data replaces the older byte.
- R4: The cycle starts only if cs_rise_i arrives while bit_cnt_i equals 0 and at least one byte was stored. Otherwise the block returns to idle with no busy interval and no write.
- R5: busy_o rises in the cycle after the qualifying cs_rise_i and stays high for exactly PROG_CYCLES clock cycles.
- R6: wen_clr_o is a single-cycle pulse in the last busy cycle. It occurs once per busy interval and at no other time.
- R7: A command started with wen_i=0 ignores its bytes and its chip-select edge, and produces no busy interval and no write.
- R8: A buffered byte is written only when allow_i is 1 for the address shown on mem_addr_o in that cycle.
- R9: Only entries that received a byte are written. At most one entry is written per clock, only while busy_o is 1. Each write goes to {page, offset} and carries the last byte stored at that offset.
- R10: start_i, byte_valid_i and cs_rise_i have no effect while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Write command opened (one-cycle strobe) |
| wen_i | input | 1 | Write-enable latch state at start |
| base_addr_i | input | 13 | Target address of the first byte |
| byte_valid_i | input | 1 | A full data byte has been received |
| byte_data_i | input | 8 | Received data byte |
| bit_cnt_i | input | 3 | Bits received of the byte in progress (0 = aligned) |
| cs_rise_i | input | 1 | Chip-select rising edge pulse |
| allow_i | input | 1 | Protection answer for mem_addr_o |
| busy_o | output | 1 | Programming in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 13 | Array write address, also the protection query |
| mem_data_o | output | 8 | Array write data |
| wen_clr_o | output | 1 | Request to clear the write-enable latch |

## Verification
The hardest case is a page that has wrapped and also straddles a protection boundary. In that case the busy interval must still run for its full length while some offsets hold replaced data and others are refused. The stimulus table reaches it with bursts longer than a page, bursts that start near the page end, and a boundary placed in the middle of a page. For each of these it checks the committed contents and the addresses that stay untouched. A directed test pushes a complete second command into the middle of a busy interval, and another resets the block mid-cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_DROP,
    ST_PROG
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              any_valid_o
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [PAGE_BYTES-1:0] hit;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : gen_hit
    assign hit[i] = wr_i && (wr_idx_i == OFF_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (clr_i) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q | hit;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (hit[i]) data_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o   = data_q[rd_idx_i];
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign any_valid_o = |valid_q;
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  output logic [OFF_W-1:0] idx_o,
  output logic             active_o
);
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(PAGE_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o    <= '0;
      active_o <= 1'b0;
    end else if (arm_i) begin
      idx_o    <= '0;
      active_o <= 1'b1;
    end else if (active_o) begin
      idx_o <= idx_o + 1'b1;
      if (idx_o == LAST_IDX) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int PROG_CYCLES = 625000,
  localparam int TMR_W      = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic run_i,
  output logic done_o
);
  localparam logic [TMR_W-1:0] LAST_CNT = TMR_W'(PROG_CYCLES - 1);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (arm_i) begin
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == LAST_CNT);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 625000,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - OFF_W,
  localparam int BIT_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic [BIT_W-1:0]  bit_cnt_i,
  input  logic              cs_rise_i,
  input  logic              allow_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              wen_clr_o
);
  pwb_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  ptr_q;
  logic              buf_clr, buf_wr, any_valid, rd_valid;
  logic [OFF_W-1:0]  scan_idx;
  logic              scan_active, arm, tmr_done, in_prog;

  assign in_prog = (state_q == ST_PROG);
  assign buf_clr = (state_q == ST_IDLE) && start_i;
  assign buf_wr  = (state_q == ST_FILL) && byte_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = wen_i ? ST_FILL : ST_DROP;
      ST_FILL: if (cs_rise_i)
                 state_d = ((bit_cnt_i == '0) && any_valid) ? ST_PROG : ST_IDLE;
      ST_DROP: if (cs_rise_i) state_d = ST_IDLE;
      ST_PROG: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign arm = (state_q == ST_FILL) && (state_d == ST_PROG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (buf_clr) begin
        page_q <= base_addr_i[ADDR_W-1:OFF_W];
        ptr_q  <= base_addr_i[OFF_W-1:0];
      end else if (buf_wr) begin
        ptr_q <= ptr_q + 1'b1;  // wraps inside the page
      end
    end
  end

  pwb_page_buf #(
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (buf_clr),
    .wr_i       (buf_wr),
    .wr_idx_i   (ptr_q),
    .wr_data_i  (byte_data_i),
    .rd_idx_i   (scan_idx),
    .rd_data_o  (mem_data_o),
    .rd_valid_o (rd_valid),
    .any_valid_o(any_valid)
  );

  pwb_commit_seq #(
    .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .idx_o   (scan_idx),
    .active_o(scan_active)
  );

  pwb_timer #(
    .PROG_CYCLES(PROG_CYCLES)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm),
    .run_i (in_prog),
    .done_o(tmr_done)
  );

  assign busy_o     = in_prog;
  assign mem_addr_o = {page_q, scan_idx};
  assign mem_we_o   = in_prog && scan_active && rd_valid && allow_i;
  assign wen_clr_o  = tmr_done;
endmodule

// File: rtl/pwb_page_writer_checker.sv
module pwb_page_writer_checker #(
  parameter int PROG_CYCLES = 625000,
  localparam int LEN_W      = $clog2(PROG_CYCLES + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_rise_i,
  input logic allow_i,
  input logic busy_o,
  input logic mem_we_o,
  input logic wen_clr_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (busy_o) len_q <= len_q + 1'b1;
    else             len_q <= '0;
  end

  assert_busy_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i));
  assert_busy_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wen_clr_o) |=> busy_o);
  assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len_q == LEN_W'(PROG_CYCLES)));
  assert_clr_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |-> busy_o);
  assert_clr_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |=> !busy_o);
  assert_we_allowed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> allow_i);
  assert_we_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
endmodule

bind pwb_page_writer pwb_page_writer_checker #(
  .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_rise_i(cs_rise_i),
  .allow_i  (allow_i),
  .busy_o   (busy_o),
  .mem_we_o (mem_we_o),
  .wen_clr_o(wen_clr_o)
);

// File: tb/pwb_page_writer_bench.sv
module pwb_page_writer_bench;
  localparam int PROG = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, wen_i = 1'b0, byte_valid_i = 1'b0, cs_rise_i = 1'b0;
  logic [12:0] base_addr_i = '0;
  logic [7:0]  byte_data_i = '0;
  logic [2:0]  bit_cnt_i = '0;
  logic [13:0] prot_lo = 14'h2000;
  logic        allow_i, busy_o, mem_we_o, wen_clr_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  int errors = 0, checks = 0;
  int wr_cnt = 0, clr_cnt = 0, busy_cnt = 0;
  logic [7:0] mem [int];

  always #4 clk = ~clk;

  assign allow_i = ({1'b0, mem_addr_o} < prot_lo);

  pwb_page_writer #(.PROG_CYCLES(PROG)) u_pwb_page_writer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .wen_i(wen_i),
    .base_addr_i(base_addr_i), .byte_valid_i(byte_valid_i),
    .byte_data_i(byte_data_i), .bit_cnt_i(bit_cnt_i), .cs_rise_i(cs_rise_i),
    .allow_i(allow_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .wen_clr_o(wen_clr_o)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_we_o) begin
        wr_cnt++;
        mem[int'(mem_addr_o)] = mem_data_o;
      end
      if (wen_clr_o) clr_cnt++;
      if (busy_o) busy_cnt++;
    end
  end

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(logic [12:0] base, int k);
    return base[7:0] ^ 8'(k * 7 + 1);
  endfunction

  typedef struct packed {
    logic        wen;
    logic [12:0] base;
    logic [5:0]  nbytes;
    logic        aligned;
    logic [13:0] prot;
    logic [5:0]  exp_wr;
    logic        exp_busy;
  } vec_t;

  localparam vec_t VECS[7] = '{
    '{1'b1, 13'h0040, 6'd4,  1'b1, 14'h2000, 6'd4,  1'b1},  // R2 plain
    '{1'b1, 13'h005E, 6'd5,  1'b1, 14'h2000, 6'd5,  1'b1},  // R3 wrap
    '{1'b1, 13'h0100, 6'd40, 1'b1, 14'h2000, 6'd32, 1'b1},  // R3 overwrite
    '{1'b0, 13'h0200, 6'd3,  1'b1, 14'h2000, 6'd0,  1'b0},  // R7 discard
    '{1'b1, 13'h0200, 6'd3,  1'b0, 14'h2000, 6'd0,  1'b0},  // R4 misaligned
    '{1'b1, 13'h0280, 6'd0,  1'b1, 14'h2000, 6'd0,  1'b0},  // R4 no byte
    '{1'b1, 13'h1FEE, 6'd4,  1'b1, 14'h1FF0, 6'd2,  1'b1}   // R8 partial protect
  };

  task automatic send(logic wen, logic [12:0] base, int n, bit aligned);
    @(negedge clk);
    start_i = 1'b1; wen_i = wen; base_addr_i = base;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_valid_i = 1'b1; byte_data_i = dat(base, k);
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
    bit_cnt_i = aligned ? 3'd0 : 3'd3;
    cs_rise_i = 1'b1;
    @(negedge clk);
    cs_rise_i = 1'b0; bit_cnt_i = 3'd0;
  endtask

  task automatic run_vec(vec_t v);
    int w0, c0, blen;
    logic [7:0] exp_d [32];
    bit         exp_v [32];
    logic [12:0] a;
    w0 = wr_cnt; c0 = clr_cnt;
    prot_lo = v.prot;
    send(v.wen, v.base, int'(v.nbytes), v.aligned);
    check(v.exp_busy ? "R5 busy rise" : "R4/R7 no busy", busy_o == v.exp_busy,
          busy_o, v.exp_busy);
    blen = 0;
    while (busy_o && blen < 1000) begin
      blen++;
      @(negedge clk);
    end
    check("R5 busy length", blen == (v.exp_busy ? PROG : 0), blen, v.exp_busy ? PROG : 0);
    check("R9 write count", (wr_cnt - w0) == int'(v.exp_wr), wr_cnt - w0, v.exp_wr);
    check("R6 clear pulses", (clr_cnt - c0) == int'(v.exp_busy), clr_cnt - c0, v.exp_busy);
    for (int j = 0; j < 32; j++) exp_v[j] = 1'b0;
    for (int k = 0; k < int'(v.nbytes); k++) begin
      exp_v[(int'(v.base[4:0]) + k) % 32] = 1'b1;
      exp_d[(int'(v.base[4:0]) + k) % 32] = dat(v.base, k);
    end
    if (v.exp_busy) begin
      for (int j = 0; j < 32; j++) begin
        if (exp_v[j]) begin
          a = {v.base[12:5], 5'(j)};
          if ({1'b0, a} < v.prot)
            check("R2/R3 content", mem.exists(int'(a)) && mem[int'(a)] == exp_d[j],
                  mem.exists(int'(a)) ? mem[int'(a)] : -1, exp_d[j]);
          else
            check("R8 protected untouched", !mem.exists(int'(a)), 1, 0);
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0, b0, c0;
    #1;
    check("R1 reset busy", busy_o == 1'b0, busy_o, 0);
    check("R1 reset we", mem_we_o == 1'b0 && wen_clr_o == 1'b0, {mem_we_o, wen_clr_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", busy_o == 1'b0 && wen_clr_o == 1'b0, busy_o, 0);

    for (int i = 0; i < 7; i++) run_vec(VECS[i]);

    // R10: full command pushed into a busy interval
    prot_lo = 14'h2000;
    w0 = wr_cnt; b0 = busy_cnt; c0 = clr_cnt;
    send(1'b1, 13'h0300, 1, 1'b1);
    repeat (5) @(negedge clk);
    send(1'b1, 13'h0400, 2, 1'b1);
    repeat (PROG + 20) @(negedge clk);
    check("R10 busy total", (busy_cnt - b0) == PROG, busy_cnt - b0, PROG);
    check("R10 writes", (wr_cnt - w0) == 1, wr_cnt - w0, 1);
    check("R10 no late write", !mem.exists(32'h400), 1, 0);
    check("R10 one clear", (clr_cnt - c0) == 1, clr_cnt - c0, 1);
    check("R9 single byte data", mem.exists(32'h300) && mem[32'h300] == dat(13'h0300, 0),
          mem.exists(32'h300) ? mem[32'h300] : -1, dat(13'h0300, 0));

    // R1: reset in the middle of a busy interval
    c0 = clr_cnt;
    send(1'b1, 13'h0500, 2, 1'b1);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid reset busy", busy_o == 1'b0 && wen_clr_o == 1'b0, busy_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (PROG) @(negedge clk);
    check("R1 stays idle", busy_o == 1'b0 && (clr_cnt - c0) == 0, clr_cnt - c0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule